// File: doc/BRIEF.md
# Controller Watchdog With Read-Kick and Latched Fault

This block watches an external controller that programs a driver device through a register interface. The block is turned on by a software enable bit, which is cleared at reset. When enabled, a down-counter runs on a slow tick of nominally 1 kHz. Its start value is one of four intervals, picked by a 2-bit delay-select field. The controller proves that it is alive by reading register address 0x00. Each such read reloads the counter.

If the counter runs out, the block sets a fault status bit and drives an active-low fault pin. The driver logic next to it uses that pin to halt the power stage. The fault stays latched until the controller writes 1 to a clear-fault bit. That bit clears itself. The serial shifter sits in front of this block and delivers one-cycle read and write strobes together with the address and the write data. The block returns read data on the same cycle as the read strobe.

Top module: `ctl_wdog`

## Requirements
- R1: After reset the enable bit and the delay-select field are 0, the fault is clear, and fault_n_o is 1. While the block is disabled, no number of ticks sets a fault.
- R2: The control register sits at address 0x01. Bit 0 is the enable bit and bits 2:1 are the delay select. A read of 0x01 returns both fields in those positions. Delay-select values 0, 1, 2 and 3 pick intervals of 10, 20, 50 and 100 ticks.
- R3: After the counter is armed or reloaded, if no reload follows, the fault is set on the edge that samples the Nth tick, where N is the selected interval. After N-1 ticks, no fault is present.
- R4: A read of address 0x00 while enabled reloads the counter to the full interval. A reload in the same cycle as the final tick wins, and no fault is set.
- R5: Reads of any address other than 0x00, and all writes (including a write to 0x00), do not reload the counter.
- R6: On expiry, fault_n_o goes to 0 and status bit 0, read at address 0x00, goes to 1.
- R7: Once set, the fault stays set through address-0x00 reads, through further ticks and through disabling. It clears only on a write of 1 to the clear-fault bit.
- R8: The clear-fault bit is bit 3 of the control register. It always reads back 0. Writing it while enabled also reloads the counter.
- R9: Clearing the enable bit stops and reloads the counter but leaves a latched fault in place. Re-enabling restarts a full interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse from the time-base prescaler |
| rd_en_i | input | 1 | Decoded register read strobe |
| wr_en_i | input | 1 | Decoded register write strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Register write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle of rd_en_i |
| fault_n_o | output | 1 | Active-low watchdog fault |

## Verification
The assertions assume the following about the inputs:
- the read and write strobes never occur in the same cycle;
- each strobe lasts one cycle;
- tick_i is a one-cycle pulse that can coincide with a strobe.

The bench drives every bus access and every tick from tasks on the falling edge, so both strobes are never raised together. The one deliberate overlap of a tick with a kick read is made by raising both in the same task step. The fault pin is checked after the edge that samples the last tick, because the fault flop updates on that edge.

// File: rtl/wd_pkg.sv
package wd_pkg;
  localparam int unsigned SEL_W        = 2;
  localparam int unsigned NUM_DLY      = 1 << SEL_W;
  localparam int unsigned STAT_ADDR    = 0;
  localparam int unsigned CTRL_ADDR    = 1;
  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_SEL_LSB = 1;
  localparam int unsigned CTRL_CLR_BIT = 3;
  localparam int unsigned STAT_FLT_BIT = 0;

  typedef struct packed {
    logic             en;
    logic [SEL_W-1:0] sel;
  } wd_cfg_t;
endpackage

// File: rtl/wd_regs.sv
module wd_regs
  import wd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              fault_i,
  output wd_cfg_t           cfg_q_o,
  output wd_cfg_t           cfg_d_o,
  output logic              kick_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic    stat_hit, ctrl_hit, ctrl_wr;
  wd_cfg_t cfg_q, cfg_d;
  logic    unused_wdata;

  assign stat_hit = addr_i == ADDR_W'(STAT_ADDR);
  assign ctrl_hit = addr_i == ADDR_W'(CTRL_ADDR);
  assign ctrl_wr  = wr_en_i && ctrl_hit;
  assign unused_wdata = ^wdata_i;

  always_comb begin
    cfg_d = cfg_q;
    if (ctrl_wr) begin
      cfg_d.en  = wdata_i[CTRL_EN_BIT];
      cfg_d.sel = wdata_i[CTRL_SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= cfg_d;
  end

  assign kick_o = rd_en_i && stat_hit;
  assign clr_o  = ctrl_wr && wdata_i[CTRL_CLR_BIT];

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (stat_hit) begin
        rdata_o[STAT_FLT_BIT] = fault_i;
      end else if (ctrl_hit) begin
        rdata_o[CTRL_EN_BIT]                = cfg_q.en;
        rdata_o[CTRL_SEL_LSB +: SEL_W]      = cfg_q.sel;
      end
    end
  end

  assign cfg_q_o = cfg_q;
  assign cfg_d_o = cfg_d;
endmodule

// File: rtl/wd_timer.sv
module wd_timer
  import wd_pkg::*;
#(
  parameter int unsigned DLY_TICKS [NUM_DLY] = '{10, 20, 50, 100}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             kick_i,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic             expire_o
);
  function automatic int unsigned max_dly();
    int unsigned m = 0;
    for (int i = 0; i < int'(NUM_DLY); i++)
      if (DLY_TICKS[i] > m) m = DLY_TICKS[i];
    return m;
  endfunction

  localparam int unsigned CNT_W = $clog2(max_dly() + 1);

  logic [CNT_W-1:0] ival [NUM_DLY];
  logic [CNT_W-1:0] cnt_q;
  logic             reload;

  for (genvar g = 0; g < int'(NUM_DLY); g++) begin : g_ival
    assign ival[g] = CNT_W'(DLY_TICKS[g]);
  end

  // disabled: hold at the interval picked by the next cfg, so enabling arms a full window
  assign reload   = !en_i || kick_i || clr_i;
  assign expire_o = en_i && tick_i && !kick_i && !clr_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= ival[0];
    else if (reload)                   cnt_q <= ival[sel_i];
    else if (tick_i && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/wd_fault.sv
module wd_fault (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fault_o <= 1'b0;
    else if (clr_i)  fault_o <= 1'b0;
    else if (set_i)  fault_o <= 1'b1;
  end
endmodule

// File: rtl/ctl_wdog.sv
module ctl_wdog
  import wd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DLY_TICKS [NUM_DLY] = '{10, 20, 50, 100}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              fault_n_o
);
  wd_cfg_t cfg_q, cfg_d;
  logic    kick, clr, expire, fault_q, wd_en;

  wd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .fault_i (fault_q),
    .cfg_q_o (cfg_q),
    .cfg_d_o (cfg_d),
    .kick_o  (kick),
    .clr_o   (clr),
    .rdata_o (rdata_o)
  );

  assign wd_en = cfg_q.en;

  wd_timer #(.DLY_TICKS(DLY_TICKS)) i_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (wd_en),
    .sel_i    (cfg_d.sel),
    .kick_i   (kick),
    .clr_i    (clr),
    .tick_i   (tick_i),
    .expire_o (expire)
  );

  wd_fault i_fault (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (expire),
    .clr_i   (clr),
    .fault_o (fault_q)
  );

  assign fault_n_o = ~fault_q;
endmodule

// File: rtl/wd_chk.sv
module wd_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              fault_n_o,
  input logic              wd_en
);
  logic stat_rd, ctrl_rd, clr_wr;
  assign stat_rd = rd_en_i && addr_i == ADDR_W'(0);
  assign ctrl_rd = rd_en_i && addr_i == ADDR_W'(1);
  assign clr_wr  = wr_en_i && addr_i == ADDR_W'(1) && wdata_i[3];

  p_no_fault_disabled_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en |=> !$fell(fault_n_o));

  p_fault_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_n_o) |-> $past(tick_i));

  p_kick_holds_pin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wd_en && stat_rd) |=> $stable(fault_n_o));

  p_status_matches_pin_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd |-> (rdata_o[0] == !fault_n_o));

  p_fault_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_n_o && !clr_wr) |=> !fault_n_o);

  p_clear_releases_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> fault_n_o);

  p_clr_reads_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |-> !rdata_o[3]);
endmodule

bind ctl_wdog wd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .rd_en_i   (rd_en_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .fault_n_o (fault_n_o),
  .wd_en     (wd_en)
);

// File: tb/test_ctl_wdog.sv
`timescale 1ns/1ps
module test_ctl_wdog;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam time TCK = 8ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          fault_n;

  int n_chk = 0;
  int n_fail = 0;

  always #(TCK/2) clk = ~clk;

  ctl_wdog #(.ADDR_W(AW), .DATA_W(DW)) i_ctl_wdog (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .fault_n_o(fault_n)
  );

  // act: 0 none, 1 read 0x00, 2 read 0x05, 3 write 0xFF to 0x00
  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] pre;
    logic [1:0] act;
    logic [7:0] post;
    logic       flt;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'd9,   2'd0, 8'd0,  1'b0},
    '{2'd0, 8'd10,  2'd0, 8'd0,  1'b1},
    '{2'd1, 8'd19,  2'd0, 8'd0,  1'b0},
    '{2'd1, 8'd20,  2'd0, 8'd0,  1'b1},
    '{2'd2, 8'd49,  2'd0, 8'd0,  1'b0},
    '{2'd2, 8'd50,  2'd0, 8'd0,  1'b1},
    '{2'd3, 8'd99,  2'd0, 8'd0,  1'b0},
    '{2'd3, 8'd100, 2'd0, 8'd0,  1'b1},
    '{2'd0, 8'd9,   2'd1, 8'd9,  1'b0},
    '{2'd0, 8'd9,   2'd1, 8'd10, 1'b1},
    '{2'd1, 8'd15,  2'd2, 8'd5,  1'b1},
    '{2'd1, 8'd15,  2'd3, 8'd5,  1'b1},
    '{2'd2, 8'd40,  2'd1, 8'd49, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #2 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(TCK * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    string tag;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin", int'(fault_n), 1);
    rd(6'h01, d); check("R1 ctrl", int'(d), 0);
    rd(6'h00, d); check("R1 status", int'(d), 0);
    ticks(120);
    check("R1 disabled ticks", int'(fault_n), 1);

    // R2 readback, R8 clear bit reads 0
    wr(6'h01, 8'h05); rd(6'h01, d); check("R2 readback", int'(d), 5);
    wr(6'h01, 8'h0F); rd(6'h01, d); check("R8 clr reads 0", int'(d), 7);
    wr(6'h01, 8'h08);

    for (int i = 0; i < NV; i++) begin
      wr(6'h01, 8'h08);
      wr(6'h01, {5'd0, VEC[i].sel, 1'b1});
      ticks(int'(VEC[i].pre));
      case (VEC[i].act)
        2'd1: rd(6'h00, d);
        2'd2: rd(6'h05, d);
        2'd3: wr(6'h00, 8'hFF);
        default: ;
      endcase
      ticks(int'(VEC[i].post));
      tag = (VEC[i].act == 2'd0) ? "R3" : (VEC[i].act == 2'd1) ? "R4" : "R5";
      check($sformatf("%s vec %0d pin", tag, i), int'(fault_n), int'(!VEC[i].flt));
      rd(6'h00, d);
      check($sformatf("R6 vec %0d status", i), int'(d[0]), int'(VEC[i].flt));
    end

    // R4 kick coincides with final tick
    wr(6'h01, 8'h09);
    ticks(9);
    @(negedge clk); tick = 1'b1; rd_en = 1'b1; addr = 6'h00;
    @(negedge clk); tick = 1'b0; rd_en = 1'b0;
    check("R4 kick on last tick", int'(fault_n), 1);
    ticks(9);
    check("R4 reload 9", int'(fault_n), 1);
    ticks(1);
    check("R4 reload 10", int'(fault_n), 0);

    // R7 latch survives kick, ticks, disable; R9 disable keeps fault
    rd(6'h00, d);
    check("R7 after kick", int'(fault_n), 0);
    wr(6'h01, 8'h00);
    ticks(5);
    check("R9 disable keeps fault", int'(fault_n), 0);
    rd(6'h00, d);
    check("R7 status held", int'(d[0]), 1);
    wr(6'h01, 8'h08);
    check("R7 clear", int'(fault_n), 1);

    // R8 clear write reloads while enabled
    wr(6'h01, 8'h01);
    ticks(9);
    wr(6'h01, 8'h09);
    ticks(9);
    check("R8 reload 9", int'(fault_n), 1);
    ticks(1);
    check("R8 reload 10", int'(fault_n), 0);

    // R9 disable reloads counter
    wr(6'h01, 8'h09);
    ticks(9);
    wr(6'h01, 8'h00);
    wr(6'h01, 8'h01);
    ticks(9);
    check("R9 rearm 9", int'(fault_n), 1);
    ticks(1);
    check("R9 rearm 10", int'(fault_n), 0);

    finish_run();
  end
endmodule